// File: doc/BRIEF.md
# Paged MDIO to 32-bit Register Bridge

This block sits behind an MDIO slave decoder and lets a management host reach a 32-bit internal register space using only 16-bit management transactions. Each decoded transaction arrives as a PHY address, a register number, 16 bits of write data and a one-cycle read or write strobe. The bridge forms an internal word address from three parts. A 9-bit page register supplies the high bits, the low three bits of the PHY address supply the middle bits, and the register number without its lowest bit supplies the low bits. Software forms the word address by dropping the two low bits of a byte address.

Every 32-bit word is exposed as a pair of 16-bit registers. The even register holds bits 15:0 and the odd register holds bits 31:16. Software writes the odd half first. The bridge stages it and issues a single 32-bit internal write only when the even half arrives. Software reads the even half first. That read fetches the whole word over the internal bus and keeps the upper half, so the odd read that follows returns the upper half of the same word. The page register is written at a fixed location outside the data window.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset all outputs are zero, the page register is zero and the staging and upper-half latches are zero.
- R2: A write to PHY 0x1F, register 0x10 loads the page register from write data bits 8:0. A read of that location returns the page zero-extended to 16 bits, with `mdio_rvalid` one cycle after the strobe.
- R3: For PHY addresses 0x10 to 0x17 the internal word address is {page[8:0], phy[2:0], reg[4:1]}, 16 bits in total.
- R4: A write to an odd register in the window only stages the 16-bit data and causes no internal bus cycle.
- R5: A write to an even register in the window makes `bus_wr` high for exactly one cycle, on the cycle after the strobe. The bus data is {staged upper half, written lower half}.
- R6: A read of an even register in the window makes `bus_rd` high for one cycle, on the cycle after the strobe. On the following cycle `mdio_rvalid` pulses and `mdio_rdata` holds bits 15:0 of `bus_rdata`.
- R7: A read of an odd register in the window causes no bus cycle. One cycle after the strobe it returns bits 31:16 captured by the last even read, even if the word has been written since.
- R8: The staged upper half persists, so consecutive even writes without an odd write reuse it.
- R9: Transactions to any other PHY address, or to PHY 0x1F with a register other than 0x10, have no effect. Writes leave the page and staging unchanged and start no bus cycle. Reads start no bus cycle and return 0xFFFF one cycle after the strobe.
- R10: If a read and a write strobe arrive in the same cycle, only the write is performed and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_phy_addr | input | 5 | Decoded PHY address of the transaction |
| mdio_reg_addr | input | 5 | Decoded register number of the transaction |
| mdio_wdata | input | 16 | Write data of the transaction |
| mdio_wr | input | 1 | One-cycle write strobe |
| mdio_rd | input | 1 | One-cycle read strobe |
| mdio_rdata | output | 16 | Read data, valid while `mdio_rvalid` is high and held afterwards |
| mdio_rvalid | output | 1 | One-cycle pulse when read data is ready |
| bus_addr | output | 16 | Internal word address |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | Internal write strobe |
| bus_rd | output | 1 | Internal read strobe; `bus_rdata` is sampled in the same cycle |
| bus_rdata | input | 32 | Internal read data |

## Verification
Random sequences mix page changes, paired writes and paired reads across all eight window PHY addresses and all sixteen register pairs. Every read is compared with a reference model that tracks the writes, and the bus address seen is checked against the expected address. This separates errors in how the address is built (page, PHY bits or register bits misplaced) from errors in half ordering (swapped halves or an early commit). Directed cases cover further points. A lone odd write shows whether the commit is deferred. Repeated even writes show whether the staged half persists. An odd read after the word is rewritten shows whether the latch is coherent. Stray PHY addresses and the both-strobes case check that filtering and strobe priority work.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    typedef enum logic [1:0] {
        TXN_NONE = 2'd0,
        TXN_PAGE = 2'd1,
        TXN_LOW  = 2'd2,
        TXN_HIGH = 2'd3
    } txn_kind_e;

endpackage

// File: rtl/mdio_addr_decode.sv
module mdio_addr_decode
    import mdio_bridge_pkg::*;
#(
    parameter int          PHY_W    = 5,
    parameter int          REG_W    = 5,
    parameter int          SEL_W    = 3,
    parameter logic [4:0]  WIN_PHY  = 5'h10,
    parameter logic [4:0]  PAGE_PHY = 5'h1F,
    parameter logic [4:0]  PAGE_REG = 5'h10,
    localparam int         LO_W     = SEL_W + REG_W - 1
) (
    input  logic [PHY_W-1:0] phy_addr,
    input  logic [REG_W-1:0] reg_addr,
    output txn_kind_e        kind,
    output logic [LO_W-1:0]  word_lo
);

    logic in_window;

    always_comb begin
        in_window = (phy_addr[PHY_W-1:SEL_W] == WIN_PHY[PHY_W-1:SEL_W]);
        word_lo   = {phy_addr[SEL_W-1:0], reg_addr[REG_W-1:1]};
        if (in_window) begin
            kind = reg_addr[0] ? TXN_HIGH : TXN_LOW;
        end else if (phy_addr == PAGE_PHY[PHY_W-1:0] && reg_addr == PAGE_REG[REG_W-1:0]) begin
            kind = TXN_PAGE;
        end else begin
            kind = TXN_NONE;
        end
    end

endmodule

// File: rtl/mdio_bridge_core.sv
module mdio_bridge_core
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int LO_W   = 7,
    parameter int HALF_W = 16,
    localparam int AW    = PAGE_W + LO_W,
    localparam int DW    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  txn_kind_e         kind,
    input  logic [LO_W-1:0]   word_lo,
    input  logic [HALF_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [DW-1:0]     bus_rdata,
    output logic [HALF_W-1:0] rdata,
    output logic              rvalid,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [HALF_W-1:0] stage;
        logic [HALF_W-1:0] hi_latch;
        logic [HALF_W-1:0] rdata;
        logic              rvalid;
        logic [AW-1:0]     bus_addr;
        logic [DW-1:0]     bus_wdata;
        logic              bus_wr;
        logic              bus_rd;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.bus_wr = 1'b0;
        st_d.bus_rd = 1'b0;
        st_d.rvalid = 1'b0;

        // complete an internal read issued on the previous cycle
        if (st_q.bus_rd) begin
            st_d.rdata    = bus_rdata[HALF_W-1:0];
            st_d.hi_latch = bus_rdata[DW-1:HALF_W];
            st_d.rvalid   = 1'b1;
        end

        if (wr) begin
            unique case (kind)
                TXN_PAGE: st_d.page  = wdata[PAGE_W-1:0];
                TXN_HIGH: st_d.stage = wdata;
                TXN_LOW: begin
                    st_d.bus_wr    = 1'b1;
                    st_d.bus_addr  = {st_q.page, word_lo};
                    st_d.bus_wdata = {st_q.stage, wdata};
                end
                default: ;
            endcase
        end else if (rd) begin
            unique case (kind)
                TXN_PAGE: begin
                    st_d.rdata  = HALF_W'(st_q.page);
                    st_d.rvalid = 1'b1;
                end
                TXN_HIGH: begin
                    st_d.rdata  = st_q.hi_latch;
                    st_d.rvalid = 1'b1;
                end
                TXN_LOW: begin
                    st_d.bus_rd   = 1'b1;
                    st_d.bus_addr = {st_q.page, word_lo};
                end
                default: begin
                    st_d.rdata  = '1;
                    st_d.rvalid = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign rvalid    = st_q.rvalid;
    assign bus_addr  = st_q.bus_addr;
    assign bus_wdata = st_q.bus_wdata;
    assign bus_wr    = st_q.bus_wr;
    assign bus_rd    = st_q.bus_rd;

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int         PAGE_W   = 9,
    parameter int         SEL_W    = 3,
    parameter int         HALF_W   = 16,
    parameter logic [4:0] WIN_PHY  = 5'h10,
    parameter logic [4:0] PAGE_PHY = 5'h1F,
    parameter logic [4:0] PAGE_REG = 5'h10,
    localparam int        PHY_W    = 5,
    localparam int        REG_W    = 5,
    localparam int        LO_W     = SEL_W + REG_W - 1,
    localparam int        AW       = PAGE_W + LO_W,
    localparam int        DW       = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  mdio_phy_addr,
    input  logic [REG_W-1:0]  mdio_reg_addr,
    input  logic [HALF_W-1:0] mdio_wdata,
    input  logic              mdio_wr,
    input  logic              mdio_rd,
    output logic [HALF_W-1:0] mdio_rdata,
    output logic              mdio_rvalid,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DW-1:0]     bus_rdata
);

    txn_kind_e       kind;
    logic [LO_W-1:0] word_lo;

    mdio_addr_decode #(
        .PHY_W    (PHY_W),
        .REG_W    (REG_W),
        .SEL_W    (SEL_W),
        .WIN_PHY  (WIN_PHY),
        .PAGE_PHY (PAGE_PHY),
        .PAGE_REG (PAGE_REG)
    ) decode_i (
        .phy_addr (mdio_phy_addr),
        .reg_addr (mdio_reg_addr),
        .kind     (kind),
        .word_lo  (word_lo)
    );

    mdio_bridge_core #(
        .PAGE_W (PAGE_W),
        .LO_W   (LO_W),
        .HALF_W (HALF_W)
    ) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .word_lo   (word_lo),
        .wdata     (mdio_wdata),
        .wr        (mdio_wr),
        .rd        (mdio_rd),
        .bus_rdata (bus_rdata),
        .rdata     (mdio_rdata),
        .rvalid    (mdio_rvalid),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd)
    );

endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mdio_phy_addr,
    input logic [15:0] mdio_wdata,
    input logic        mdio_wr,
    input logic        mdio_rd,
    input logic        mdio_rvalid,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd
);

    // R5: an internal write only follows a write strobe
    p_wr_follows_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(mdio_wr));

    // R5: lower half of the bus word is the data of the even write
    p_wr_low_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_wdata[15:0] == $past(mdio_wdata));

    // R6 / R10: an internal read only follows a read strobe without a write
    p_rd_follows_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ($past(mdio_rd) && !$past(mdio_wr)));

    // R6: read data is returned the cycle after the internal read
    p_rd_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> mdio_rvalid);

    // R10: never both bus strobes at once
    p_bus_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R9: writes outside the window and the page location start nothing
    p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_wr && mdio_phy_addr[4:3] != 2'b10 && mdio_phy_addr != 5'h1F) |=> !bus_wr);

endmodule

bind mdio_page_bridge mdio_page_bridge_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mdio_phy_addr (mdio_phy_addr),
    .mdio_wdata    (mdio_wdata),
    .mdio_wr       (mdio_wr),
    .mdio_rd       (mdio_rd),
    .mdio_rvalid   (mdio_rvalid),
    .bus_wdata     (bus_wdata),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd)
);

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy = '0;
    logic [4:0]  rg = '0;
    logic [15:0] wd = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic        rvalid;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mdio_page_bridge dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mdio_phy_addr (phy),
        .mdio_reg_addr (rg),
        .mdio_wdata    (wd),
        .mdio_wr       (wr),
        .mdio_rd       (rd),
        .mdio_rdata    (rdata),
        .mdio_rvalid   (rvalid),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_rdata     (bus_rdata)
    );

    // small register file model, indexed by the low 8 word-address bits
    logic [31:0] mem [0:255];
    logic [31:0] ref_mem [0:255];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [15:0] last_addr = '0;
    logic [31:0] last_wdata = '0;

    assign bus_rdata = mem[bus_addr[7:0]];

    always @(posedge clk) begin
        if (bus_wr) begin
            mem[bus_addr[7:0]] <= bus_wdata;
            wr_cnt     = wr_cnt + 1;
            last_addr  = bus_addr;
            last_wdata = bus_wdata;
        end
        if (bus_rd) begin
            rd_cnt    = rd_cnt + 1;
            last_addr = bus_addr;
        end
    end

    function automatic logic [15:0] word_addr(input logic [8:0] pg, input logic [4:0] p,
                                              input logic [4:0] r);
        return {pg, p[2:0], r[4:1]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mdio_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        phy = p; rg = r; wd = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
    endtask

    // returns data and the number of negedges after the strobe until rvalid (0 = none)
    task automatic mdio_read(input logic [4:0] p, input logic [4:0] r,
                             output logic [15:0] d, output int lat);
        @(negedge clk);
        phy = p; rg = r; rd = 1'b1;
        lat = 0;
        d = 'x;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            rd = 1'b0;
            if (rvalid && lat == 0) begin
                lat = i;
                d = rdata;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [8:0]  page_m;
        int          lat;
        int          w0;
        int          r0;

        for (int i = 0; i < 256; i++) begin
            mem[i]     = 32'h5A00_0000 ^ (i * 32'h0001_0203);
            ref_mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
        end
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        // R1: reset state
        check(rdata == 16'h0 && !rvalid && !bus_wr && !bus_rd && bus_addr == 16'h0 &&
              bus_wdata == 32'h0, "R1 reset outputs", {rdata, bus_addr}, 32'h0);
        rst_n = 1'b1;
        mdio_read(5'h1F, 5'h10, d, lat);
        check(d == 16'h0 && lat == 1, "R1 page after reset", {16'(lat), d}, 32'h0001_0000);
        mdio_read(5'h10, 5'h01, d, lat);
        check(d == 16'h0 && lat == 1, "R1 upper latch after reset", {16'(lat), d}, 32'h0001_0000);

        // R2: page load and read back
        mdio_write(5'h1F, 5'h10, 16'hFF35);
        page_m = 9'h135;
        mdio_read(5'h1F, 5'h10, d, lat);
        check(d == 16'h0135 && lat == 1, "R2 page readback", {16'(lat), d}, 32'h0001_0135);

        // R4: odd write stages only
        w0 = wr_cnt;
        mdio_write(5'h13, 5'h0B, 16'hBEEF);
        check(wr_cnt == w0, "R4 no bus write on upper half", wr_cnt, w0);

        // R5 / R3: even write commits {staged, low}
        mdio_write(5'h13, 5'h0A, 16'hCAFE);
        check(wr_cnt == w0 + 1, "R5 one bus write", wr_cnt, w0 + 1);
        check(last_wdata == 32'hBEEF_CAFE, "R5 bus data", last_wdata, 32'hBEEF_CAFE);
        check(last_addr == word_addr(page_m, 5'h13, 5'h0A), "R3 write address",
              last_addr, word_addr(page_m, 5'h13, 5'h0A));
        ref_mem[8'(word_addr(page_m, 5'h13, 5'h0A))] = 32'hBEEF_CAFE;

        // R8: staged half reused
        mdio_write(5'h15, 5'h04, 16'h1111);
        check(last_wdata == 32'hBEEF_1111, "R8 staged half persists", last_wdata, 32'hBEEF_1111);
        ref_mem[8'(word_addr(page_m, 5'h15, 5'h04))] = 32'hBEEF_1111;

        // R6: lower read latency and data
        r0 = rd_cnt;
        mdio_read(5'h13, 5'h0A, lo, lat);
        check(lo == 16'hCAFE && lat == 2, "R6 lower read", {16'(lat), lo}, 32'h0002_CAFE);
        check(rd_cnt == r0 + 1, "R6 one bus read", rd_cnt, r0 + 1);

        // R7: coherent upper half after the word is rewritten
        mdio_write(5'h13, 5'h0B, 16'h7777);
        mdio_write(5'h13, 5'h0A, 16'h8888);
        ref_mem[8'(word_addr(page_m, 5'h13, 5'h0A))] = 32'h7777_8888;
        r0 = rd_cnt;
        mdio_read(5'h13, 5'h0B, hi, lat);
        check(hi == 16'hBEEF && lat == 1, "R7 latched upper half", {16'(lat), hi}, 32'h0001_BEEF);
        check(rd_cnt == r0, "R7 no bus read on upper half", rd_cnt, r0);

        // R9: ignored transactions
        w0 = wr_cnt; r0 = rd_cnt;
        mdio_write(5'h1F, 5'h11, 16'h0000);
        mdio_write(5'h08, 5'h10, 16'h0000);
        mdio_write(5'h03, 5'h01, 16'h0000);
        mdio_read(5'h1F, 5'h10, d, lat);
        check(d == 16'(page_m), "R9 page unchanged", d, 16'(page_m));
        mdio_read(5'h1E, 5'h02, d, lat);
        check(d == 16'hFFFF && lat == 1, "R9 ignored read", {16'(lat), d}, 32'h0001_FFFF);
        check(wr_cnt == w0 && rd_cnt == r0, "R9 no bus cycles", wr_cnt + rd_cnt, w0 + r0);
        mdio_write(5'h12, 5'h00, 16'h2222);
        check(last_wdata == 32'h7777_2222, "R9 staging unchanged", last_wdata, 32'h7777_2222);
        ref_mem[8'(word_addr(page_m, 5'h12, 5'h00))] = 32'h7777_2222;

        // R10: both strobes at once
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        phy = 5'h11; rg = 5'h06; wd = 16'h3333; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        lat = 0;
        for (int i = 0; i < 3; i++) begin
            if (rvalid) lat = 1;
            @(negedge clk);
        end
        check(wr_cnt == w0 + 1 && rd_cnt == r0 && lat == 0, "R10 write wins",
              {wr_cnt[7:0], rd_cnt[7:0], 8'(lat)}, {w0[7:0] + 8'd1, r0[7:0], 8'd0});
        ref_mem[8'(word_addr(page_m, 5'h11, 5'h06))] = 32'h7777_3333;

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [4:0] p;
            logic [4:0] r;
            logic [15:0] a;
            op = $urandom_range(0, 9);
            p  = 5'h10 | 5'($urandom_range(0, 7));
            r  = 5'($urandom_range(0, 15)) << 1;
            a  = word_addr(page_m, p, r);
            if (op == 0) begin
                page_m = 9'($urandom);
                mdio_write(5'h1F, 5'h10, 16'($urandom));
                page_m = 9'h0FF & page_m;
                mdio_write(5'h1F, 5'h10, 16'(page_m));
            end else if (op < 5) begin
                logic [31:0] v;
                v = $urandom;
                mdio_write(p, r | 5'h01, v[31:16]);
                mdio_write(p, r, v[15:0]);
                check(last_addr == a && last_wdata == v, "R3 R5 random write",
                      {last_addr, last_wdata[15:0]}, {a, v[15:0]});
                ref_mem[a[7:0]] = v;
            end else if (op < 9) begin
                mdio_read(p, r, lo, lat);
                check(last_addr == a, "R3 random read address", last_addr, a);
                mdio_read(p, r | 5'h01, hi, lat);
                check({hi, lo} == ref_mem[a[7:0]], "R6 R7 random read", {hi, lo}, ref_mem[a[7:0]]);
            end else begin
                w0 = wr_cnt;
                mdio_write(5'($urandom_range(0, 15)), r, 16'($urandom));
                check(wr_cnt == w0, "R9 random ignored write", wr_cnt, w0);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule